// File: doc/BRIEF.md
# Residue-Checked Block SAD Element

This block computes the sum of absolute differences (SAD) between the sixteen current-block and sixteen reference-block luminance pixels of one 4x4 block. It takes one pixel pair per clock. A start pulse begins a new block. One cycle after the sixteenth accepted pair, the 12-bit SAD is presented for one cycle.

Two residue predictors run alongside the SAD datapath. They use moduli 7 (2^3-1) and 15 (2^4-1). Each predictor has its own absolute-difference logic and folds every per-pair difference into a running residue, so it never looks at the SAD itself. At the end of a block, the output word, possibly corrupted by a single-bit fault-injection port, is reduced again modulo 7 and modulo 15 and compared against the predictions.

A match routes the word out on the clean path. A mismatch routes it to a downstream corrector, together with both predicted residues and both syndromes.

Top module: `sadchk_pe`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears its state. After reset, `sad_o`, `res_a_o`, `res_b_o`, `syn_a_o` and `syn_b_o` read 0 (with no flip requested), and `err_o`, `clean_valid_o` and `fix_valid_o` are low.
- R2: `sad_o` is the sum of |cur - ref| over the accepted pairs of the current block. After the 16th accepted pair, exactly one of the two valid outputs is high for exactly one cycle, the cycle following that pair's clock edge.
- R3: A pair is accepted only when `pix_valid_i` is high, `start_i` is low and fewer than 16 pairs have been accepted since the last start. A `start_i` edge clears the SAD and both residues. Pairs presented during the start cycle, while valid is low, or after the 16th pair leave the outputs unchanged.
- R4: `res_a_o` equals the accepted SAD mod 7 and `res_b_o` equals it mod 15, at all times. Both are kept in the ranges 0..6 and 0..14.
- R5: In the result cycle, `err_o` is high exactly when `sad_o` mod 7 differs from `res_a_o`, or `sad_o` mod 15 differs from `res_b_o`. Any single flipped bit at positions 0..11 therefore raises `err_o`, and with no flip `err_o` stays low.
- R6: In the result cycle, `clean_valid_o` is high when `err_o` is low, and `fix_valid_o` is high when `err_o` is high. The two valids are never high together, and both are low outside the result cycle.
- R7: `syn_a_o` = (`sad_o` - `res_a_o`) mod 7 and `syn_b_o` = (`sad_o` - `res_b_o`) mod 15. Each syndrome is zero exactly when its residue matches.
- R8: When `flip_en_i` is high and `flip_pos_i` is 0..11, bit `flip_pos_i` of the accumulated SAD is inverted on `sad_o`, combinationally in the same cycle. When `flip_pos_i` is 12..15 or `flip_en_i` is low, `sad_o` is the unmodified SAD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a new block; clears accumulators |
| pix_valid_i | input | 1 | Pixel pair present this cycle |
| cur_i | input | 8 | Current-block luminance pixel |
| ref_i | input | 8 | Reference-block luminance pixel |
| flip_en_i | input | 1 | Enable single-bit fault injection |
| flip_pos_i | input | 4 | Bit position to invert in the SAD word |
| sad_o | output | 12 | Checked SAD word (after injection) |
| res_a_o | output | 3 | Predicted residue modulo 7 |
| res_b_o | output | 4 | Predicted residue modulo 15 |
| syn_a_o | output | 3 | Syndrome modulo 7 |
| syn_b_o | output | 4 | Syndrome modulo 15 |
| err_o | output | 1 | Residue mismatch in the result cycle |
| clean_valid_o | output | 1 | Result forwarded as error-free |
| fix_valid_o | output | 1 | Result handed to the corrector |

## Verification
The bench drives several corner cases:
- **Largest SAD.** A block of all 255/0 pairs gives 4080, which exercises the top accumulator bit. Folding of a residue that reads as the all-ones value is exercised by SADs that are multiples of 7 or 15; a design that missed the all-ones-to-zero mapping would flag those as errors.
- **All-equal block.** This gives SAD 0.
- **Acceptance gating.** The bench presents a pair in the same cycle as a restart, leaves gaps in the valid input, and sends surplus pairs after the sixteenth. A design that got any of these wrong would show a shifted SAD, or a result pulse that comes early, late or twice.
- **Fault sweep.** Every flip position is tried. Positions 0..11 must each land in the corrector path with the right syndromes. Positions 12..15 must leave the word clean, so a design with a mis-decoded position would flag a phantom error or corrupt the word.

// File: rtl/sadchk_pkg.sv
package sadchk_pkg;

    parameter int PIX_W  = 8;
    parameter int PAIRS  = 16;
    parameter int SAD_W  = 12;
    parameter int A_BITS = 3;
    parameter int B_BITS = 4;

    localparam int POS_W = $clog2(SAD_W);
    localparam int CNT_W = $clog2(PAIRS + 1);

    typedef struct packed {
        logic [PIX_W-1:0] cur;
        logic [PIX_W-1:0] rf;
    } pix_pair_t;

    typedef enum logic [1:0] {
        ROUTE_IDLE  = 2'd0,
        ROUTE_CLEAN = 2'd1,
        ROUTE_FIX   = 2'd2
    } route_e;

    function automatic logic [PIX_W-1:0] pair_absdiff(input pix_pair_t p);
        logic [PIX_W-1:0] d;
        if (p.cur >= p.rf) d = p.cur - p.rf;
        else               d = p.rf - p.cur;
        return d;
    endfunction

    // Reduction modulo 2^k-1 by end-around folding of k-bit chunks.
    function automatic logic [15:0] fold_mod(input logic [15:0] v, input int k);
        logic [15:0] mask;
        logic [15:0] acc;
        mask = 16'((32'd1 << k) - 32'd1);
        acc  = v;
        for (int it = 0; it < 10; it++) begin
            acc = (acc & mask) + (acc >> k);
        end
        if (acc == mask) acc = '0;
        return acc;
    endfunction

endpackage

// File: rtl/sadchk_seq.sv
module sadchk_seq
    import sadchk_pkg::*;
#(
    parameter int N_PAIRS = PAIRS,
    parameter int C_W     = CNT_W
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic pix_valid_i,
    output logic accept_o,
    output logic done_o
);
    localparam logic [C_W-1:0] LAST = C_W'(N_PAIRS - 1);
    localparam logic [C_W-1:0] FULL = C_W'(N_PAIRS);

    logic [C_W-1:0] count_q;
    logic           done_q;

    assign accept_o = pix_valid_i && !start_i && (count_q < FULL);
    assign done_o   = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= accept_o && (count_q == LAST);
            if (start_i)       count_q <= '0;
            else if (accept_o) count_q <= count_q + 1'b1;
        end
    end

    p_count_bounded_r3: assert property (@(posedge clk) disable iff (rst)
        count_q <= FULL);

    p_start_clears_r3: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (count_q == '0));

    p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    p_done_full_r2: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (count_q == FULL));

endmodule

// File: rtl/sadchk_sad_acc.sv
module sadchk_sad_acc
    import sadchk_pkg::*;
#(
    parameter int W = SAD_W
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      accept_i,
    input  pix_pair_t pair_i,
    output logic [W-1:0] sad_o
);
    logic [W-1:0] sad_q;
    logic [W-1:0] diff_w;

    assign diff_w = W'(pair_absdiff(pair_i));
    assign sad_o  = sad_q;

    always_ff @(posedge clk) begin
        if (rst || start_i) sad_q <= '0;
        else if (accept_i)  sad_q <= sad_q + diff_w;
    end

    p_acc_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!accept_i && !start_i) |=> $stable(sad_q));

endmodule

// File: rtl/sadchk_res_coder.sv
module sadchk_res_coder
    import sadchk_pkg::*;
#(
    parameter int K = A_BITS
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      accept_i,
    input  pix_pair_t pair_i,
    output logic [K-1:0] res_o
);
    localparam logic [K-1:0] MODV = '1;

    logic [K-1:0] res_q;
    logic [K-1:0] pair_res;
    logic [K-1:0] next_res;

    always_comb begin
        pair_res = K'(fold_mod(16'(pair_absdiff(pair_i)), K));
        next_res = K'(fold_mod(16'(res_q) + 16'(pair_res), K));
    end

    assign res_o = res_q;

    always_ff @(posedge clk) begin
        if (rst || start_i) res_q <= '0;
        else if (accept_i)  res_q <= next_res;
    end

    p_res_range_r4: assert property (@(posedge clk) disable iff (rst)
        res_q < MODV);

endmodule

// File: rtl/sadchk_res_check.sv
module sadchk_res_check
    import sadchk_pkg::*;
#(
    parameter int K = A_BITS,
    parameter int W = SAD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] word_i,
    input  logic [K-1:0] pred_i,
    output logic         mismatch_o,
    output logic [K-1:0] syn_o
);
    localparam logic [K-1:0] MODV = '1;

    logic [K-1:0] word_res;

    always_comb begin
        word_res   = K'(fold_mod(16'(word_i), K));
        syn_o      = K'(fold_mod(16'(word_res) + 16'(MODV - pred_i), K));
        mismatch_o = (word_res != pred_i);
    end

    p_syn_zero_iff_match_r7: assert property (@(posedge clk) disable iff (rst)
        mismatch_o == (syn_o != '0));

endmodule

// File: rtl/sadchk_pe.sv
module sadchk_pe
    import sadchk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              pix_valid_i,
    input  logic [PIX_W-1:0]  cur_i,
    input  logic [PIX_W-1:0]  ref_i,
    input  logic              flip_en_i,
    input  logic [POS_W-1:0]  flip_pos_i,
    output logic [SAD_W-1:0]  sad_o,
    output logic [A_BITS-1:0] res_a_o,
    output logic [B_BITS-1:0] res_b_o,
    output logic [A_BITS-1:0] syn_a_o,
    output logic [B_BITS-1:0] syn_b_o,
    output logic              err_o,
    output logic              clean_valid_o,
    output logic              fix_valid_o
);
    pix_pair_t        pair;
    logic             accept;
    logic             done;
    logic [SAD_W-1:0] sad_raw;
    logic [SAD_W-1:0] flip_mask;
    logic [SAD_W-1:0] word;
    logic             mis_a;
    logic             mis_b;
    route_e           route;

    assign pair = '{cur: cur_i, rf: ref_i};

    sadchk_seq #(.N_PAIRS(PAIRS), .C_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .pix_valid_i(pix_valid_i),
        .accept_o(accept), .done_o(done)
    );

    sadchk_sad_acc #(.W(SAD_W)) u_acc (
        .clk(clk), .rst(rst), .start_i(start_i), .accept_i(accept),
        .pair_i(pair), .sad_o(sad_raw)
    );

    sadchk_res_coder #(.K(A_BITS)) u_coder_a (
        .clk(clk), .rst(rst), .start_i(start_i), .accept_i(accept),
        .pair_i(pair), .res_o(res_a_o)
    );

    sadchk_res_coder #(.K(B_BITS)) u_coder_b (
        .clk(clk), .rst(rst), .start_i(start_i), .accept_i(accept),
        .pair_i(pair), .res_o(res_b_o)
    );

    always_comb begin
        if (flip_en_i && ({1'b0, flip_pos_i} < (POS_W+1)'(SAD_W)))
            flip_mask = SAD_W'(1) << flip_pos_i;
        else
            flip_mask = '0;
    end

    assign word  = sad_raw ^ flip_mask;
    assign sad_o = word;

    sadchk_res_check #(.K(A_BITS), .W(SAD_W)) u_chk_a (
        .clk(clk), .rst(rst), .word_i(word), .pred_i(res_a_o),
        .mismatch_o(mis_a), .syn_o(syn_a_o)
    );

    sadchk_res_check #(.K(B_BITS), .W(SAD_W)) u_chk_b (
        .clk(clk), .rst(rst), .word_i(word), .pred_i(res_b_o),
        .mismatch_o(mis_b), .syn_o(syn_b_o)
    );

    always_comb begin
        if (!done)              route = ROUTE_IDLE;
        else if (mis_a | mis_b) route = ROUTE_FIX;
        else                    route = ROUTE_CLEAN;
    end

    assign err_o         = (route == ROUTE_FIX);
    assign clean_valid_o = (route == ROUTE_CLEAN);
    assign fix_valid_o   = (route == ROUTE_FIX);

    p_paths_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        !(clean_valid_o && fix_valid_o));

    p_no_flip_clean_r5: assert property (@(posedge clk) disable iff (rst)
        (done && !flip_en_i) |-> (clean_valid_o && !err_o));

    p_flip_detected_r5: assert property (@(posedge clk) disable iff (rst)
        (done && flip_en_i && ({1'b0, flip_pos_i} < (POS_W+1)'(SAD_W))) |-> err_o);

    p_flip_single_bit_r8: assert property (@(posedge clk) disable iff (rst)
        $countones(sad_o ^ sad_raw) <= 1);

endmodule

// File: tb/sadchk_pe_bench.sv
module sadchk_pe_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        pix_valid_i = 1'b0;
    logic [7:0]  cur_i = '0;
    logic [7:0]  ref_i = '0;
    logic        flip_en_i = 1'b0;
    logic [3:0]  flip_pos_i = '0;
    logic [11:0] sad_o;
    logic [2:0]  res_a_o;
    logic [3:0]  res_b_o;
    logic [2:0]  syn_a_o;
    logic [3:0]  syn_b_o;
    logic        err_o, clean_valid_o, fix_valid_o;

    always #5 clk = ~clk;

    sadchk_pe u_sadchk_pe (
        .clk(clk), .rst(rst), .start_i(start_i), .pix_valid_i(pix_valid_i),
        .cur_i(cur_i), .ref_i(ref_i), .flip_en_i(flip_en_i), .flip_pos_i(flip_pos_i),
        .sad_o(sad_o), .res_a_o(res_a_o), .res_b_o(res_b_o),
        .syn_a_o(syn_a_o), .syn_b_o(syn_b_o), .err_o(err_o),
        .clean_valid_o(clean_valid_o), .fix_valid_o(fix_valid_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int m_cnt = 0;
    int m_sum = 0;
    bit m_done = 0;

    function automatic int absd(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_sum = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (start_i) begin
                m_cnt = 0; m_sum = 0;
            end else if (pix_valid_i && m_cnt < 16) begin
                m_sum += absd(int'(cur_i), int'(ref_i));
                m_cnt++;
                if (m_cnt == 16) m_done = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            int w, ex, ey, s7, s15;
            bit e_err;
            w  = m_sum;
            if (flip_en_i && flip_pos_i < 12) w = w ^ (1 << flip_pos_i);
            ex = m_sum % 7;
            ey = m_sum % 15;
            s7  = ((w % 7) - ex + 7) % 7;
            s15 = ((w % 15) - ey + 15) % 15;
            e_err = m_done && (s7 != 0 || s15 != 0);
            check("R2/R8 sad word", int'(sad_o), w);
            check("R4 residue mod 7", int'(res_a_o), ex);
            check("R4 residue mod 15", int'(res_b_o), ey);
            check("R7 syndrome mod 7", int'(syn_a_o), s7);
            check("R7 syndrome mod 15", int'(syn_b_o), s15);
            check("R5 error flag", int'(err_o), int'(e_err));
            check("R6 clean valid", int'(clean_valid_o), int'(m_done && !e_err));
            check("R6 fix valid", int'(fix_valid_o), int'(m_done && e_err));
        end
    end

    task automatic step(input bit st, input bit v, input int c, input int r,
                        input bit fe, input int fp);
        @(negedge clk); #1;
        start_i = st; pix_valid_i = v;
        cur_i = 8'(c); ref_i = 8'(r);
        flip_en_i = fe; flip_pos_i = 4'(fp);
    endtask

    task automatic run_block(input int seed, input int kind, input bit fe, input int fp);
        int exp_sum = 0;
        step(1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 16; i++) begin
            int c, r;
            case (kind)
                0: begin c = (seed*37 + i*53) % 256; r = (seed*91 + i*29 + 7) % 256; end
                1: begin c = 255; r = 0; end
                default: begin c = (i*13) % 256; r = c; end
            endcase
            exp_sum += absd(c, r);
            step(0, 1, c, r, fe, fp);
        end
        @(negedge clk);
        if (fe && fp < 12) begin
            check("R5 single flip flagged", int'(err_o), 1);
            check("R6 flip routed to corrector", int'(fix_valid_o), 1);
        end else begin
            check("R8 word unmodified", int'(sad_o), exp_sum);
            check("R6 clean route", int'(clean_valid_o), 1);
        end
        #1;
        pix_valid_i = 0; flip_en_i = 0; flip_pos_i = '0;
        @(negedge clk);
        check("R2 result pulse ends", int'(clean_valid_o | fix_valid_o), 0);
    endtask

    initial begin
        start_i = 1; pix_valid_i = 1; cur_i = 8'd90; ref_i = 8'd10;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        rst = 0; start_i = 0; pix_valid_i = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 reset sad", int'(sad_o), 0);
        check("R1 reset residues", int'(res_a_o) + int'(res_b_o), 0);
        check("R1 reset flags", int'(err_o) + int'(clean_valid_o) + int'(fix_valid_o), 0);

        // R2 varied blocks, R4 residues
        for (int s = 0; s < 6; s++) run_block(s, 0, 0, 0);
        run_block(0, 1, 0, 0);   // R2 largest SAD 4080
        run_block(0, 2, 0, 0);   // R2 zero SAD

        // R3 restart mid-block, start-cycle pair, gaps, surplus pairs
        begin
            int es = 0;
            step(1, 0, 0, 0, 0, 0);
            for (int i = 0; i < 5; i++) step(0, 1, 100 + i, 3, 0, 0);
            step(1, 1, 200, 0, 0, 0);
            for (int i = 0; i < 16; i++) begin
                step(0, 0, 250, 1, 0, 0);
                step(0, 1, i*7, 100, 0, 0);
                es += absd(i*7, 100);
            end
            @(negedge clk);
            check("R3 gated SAD", int'(sad_o), es);
            check("R2 done after 16th pair", int'(clean_valid_o), 1);
            for (int i = 0; i < 3; i++) step(0, 1, 255, 0, 0, 0);
            @(negedge clk);
            check("R3 surplus pairs ignored", int'(sad_o), es);
            check("R3 no second pulse", int'(clean_valid_o | fix_valid_o), 0);
            check("R4 residue after surplus", int'(res_b_o), es % 15);
        end

        // R5/R8 fault sweep over every position
        for (int p = 0; p < 16; p++) run_block(p + 11, 0, 1, p);
        run_block(3, 1, 1, 11);
        run_block(4, 2, 1, 0);

        step(0, 0, 0, 0, 0, 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule